// File: doc/BRIEF.md
# Dual-Processor Interrupt Steering Arbiter

This block sits at the output stage of a two-processor interrupt controller. It decides each cycle whether each processor's interrupt line should be raised. Each processor presents its current best pending request, made of a source number, a 4-bit priority, a flag that says whether the source is external, and a flag that says whether the source also targets the other processor. Each processor also has a 4-bit task priority and a nested in-service stack of up to 16 accepted interrupts.

An external request that targets both processors is steered to exactly one of them. A processor takes it only if the other processor is not already servicing that same source, and only if its own task priority is strictly the lower of the two. When the two task priorities are equal, a tie-select input chooses the processor.

An acknowledge pushes the presented request onto that processor's in-service stack. It also emits a one-cycle pending-clear pulse for that processor alone, so that a multicast source's pending copy is cleared separately for each processor. An end-of-interrupt pops the most recent, and therefore highest-priority, in-service entry.

Top module: `dual_irq_steer`

## Requirements
- R1: While reset is held and in the first cycle after it, `irq` and `clr_vld` are 0, and both in-service stacks are empty.
- R2: For an external request whose shared flag is 0, processor k's line is raised when the request priority is strictly greater than both the top in-service priority of k (0 when the stack is empty) and `task_pri[k]`.
- R3: For an external request whose shared flag is 1, processor k's line is raised only when all of the R2 conditions hold, the source is not in the other processor's in-service stack, and `task_pri[k]` is strictly less than the other processor's task priority.
- R4: For an internal request (`req_ext[k]`=0), the decision uses only the R2 conditions. The shared flag, the other processor's stack and the other processor's task priority have no effect.
- R5: For a shared external request, if the two task priorities are equal, `tie_to_p1`=0 gives it to processor 0 and `tie_to_p1`=1 gives it to processor 1. The same shared request is never raised on both lines.
- R6: An acknowledge `ack[k]` seen while `irq[k]` is 1 produces, one cycle later, `clr_vld[k]`=1 for one cycle with `clr_src[k]` equal to the acknowledged source. The other processor's `clr_vld` is not affected.
- R7: An acknowledge while `irq[k]` is 1 pushes the presented source and priority onto stack k, unless the stack already holds DEPTH entries. An acknowledge while `irq[k]` is 0 is ignored.
- R8: `eoi[k]` pops the most recently pushed entry of stack k. It is ignored when the stack is empty, and also when an accepted acknowledge for k occurs in the same cycle.
- R9: A request of priority 0 never raises an interrupt line.
- R10: `irq` is registered. It reflects the inputs and stack state of the previous clock edge, so a change takes effect one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tie_to_p1 | input | 1 | Equal-task tie winner: 0 = processor 0, 1 = processor 1 |
| req_src | input | 2 x SRC_W | Source number of each processor's presented request |
| req_pri | input | 2 x 4 | Priority of each presented request, 0 = none |
| req_ext | input | 2 | 1 = external source, 0 = internal (timer or inter-processor) |
| req_shared | input | 2 | 1 = source's destination bit for the other processor is set |
| task_pri | input | 2 x 4 | Task priority of each processor |
| ack | input | 2 | Interrupt acknowledge per processor |
| eoi | input | 2 | End-of-interrupt per processor |
| irq | output | 2 | Registered interrupt line per processor |
| clr_vld | output | 2 | One-cycle pending-clear pulse per processor |
| clr_src | output | 2 x SRC_W | Source whose pending copy is cleared |

## Verification
The hardest case to reach is the exclusion in R3. The other processor must still hold the same source in its stack while a shared request for that source is presented and this processor wins the task comparison. The stimulus draws sources from a pool of only four and issues end-of-interrupt rarely, so stacks fill with recurring sources. It also drives many equal or near-equal task priorities, so the tie and exclusion paths are exercised often. Directed sequences cover the acknowledge-then-drop and end-of-interrupt-then-return behaviour, and both settings of the tie input.

// File: rtl/dual_irq_steer.sv
module dual_irq_steer #(
  parameter int SRC_W = 6,
  parameter int PRI_W = 4,
  parameter int DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tie_to_p1,
  input  logic [1:0][SRC_W-1:0] req_src,
  input  logic [1:0][PRI_W-1:0] req_pri,
  input  logic [1:0]            req_ext,
  input  logic [1:0]            req_shared,
  input  logic [1:0][PRI_W-1:0] task_pri,
  input  logic [1:0]            ack,
  input  logic [1:0]            eoi,
  output logic [1:0]            irq,
  output logic [1:0]            clr_vld,
  output logic [1:0][SRC_W-1:0] clr_src
);
  localparam int DW = $clog2(DEPTH + 1);

  logic [SRC_W-1:0] stk_src [2][DEPTH];
  logic [PRI_W-1:0] stk_pri [2][DEPTH];
  logic [1:0][DW-1:0]    dep;
  logic [1:0][PRI_W-1:0] top;
  logic [1:0] in_other, above, wins, want, take;

  always_comb begin
    top = '0;
    in_other = '0;
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < DEPTH; i++) begin
        if (DW'(i) < dep[k]) top[k] = stk_pri[k][i];
        if (DW'(i) < dep[1-k] && stk_src[1-k][i] == req_src[k]) in_other[k] = 1'b1;
      end
  end

  for (genvar k = 0; k < 2; k++) begin : g_rule
    assign above[k] = (req_pri[k] > top[k]) && (req_pri[k] > task_pri[k]);
    assign wins[k]  = (task_pri[k] < task_pri[1-k]) ||
                      (task_pri[k] == task_pri[1-k] && tie_to_p1 == 1'(k));
    assign want[k]  = above[k] &&
                      (!(req_ext[k] && req_shared[k]) || (!in_other[k] && wins[k]));
    assign take[k]  = ack[k] && irq[k];

    a_r7_push: assert property (@(posedge clk) disable iff (!rst_n)
      (take[k] && dep[k] < DW'(DEPTH)) |=> dep[k] == $past(dep[k]) + DW'(1));
    a_r8_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi[k] && !take[k] && dep[k] != '0) |=> dep[k] == $past(dep[k]) - DW'(1));
    a_r6_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vld[k] |-> $past(ack[k] && irq[k]));
    a_r9_zero_prio: assert property (@(posedge clk) disable iff (!rst_n)
      (req_pri[k] == '0) |=> !irq[k]);
    a_r7_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
      dep[k] <= DW'(DEPTH));
  end

  a_r5_single_taker: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ext == 2'b11 && req_shared == 2'b11 && req_src[0] == req_src[1])
    |=> irq != 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= '0;
      clr_vld <= '0;
      clr_src <= '0;
      dep     <= '0;
    end else begin
      irq     <= want;
      clr_vld <= take;
      for (int k = 0; k < 2; k++) begin
        if (take[k]) begin
          clr_src[k] <= req_src[k];
          if (dep[k] < DW'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++)
              if (DW'(i) == dep[k]) begin
                stk_src[k][i] <= req_src[k];
                stk_pri[k][i] <= req_pri[k];
              end
            dep[k] <= dep[k] + DW'(1);
          end
        end else if (eoi[k] && dep[k] != '0) begin
          dep[k] <= dep[k] - DW'(1);
        end
      end
    end
  end
endmodule

// File: tb/sim_dual_irq_steer.sv
`timescale 1ns/1ps
module sim_dual_irq_steer;
  localparam int SW = 6;
  localparam int DP = 16;

  logic clk = 1'b0, rst_n = 1'b0, tie_to_p1 = 1'b0;
  logic [1:0][SW-1:0] req_src = '0;
  logic [1:0][3:0]    req_pri = '0, task_pri = '0;
  logic [1:0]         req_ext = '0, req_shared = '0, ack = '0, eoi = '0;
  logic [1:0]         irq, clr_vld;
  logic [1:0][SW-1:0] clr_src;

  int checks = 0, errors = 0;
  string note = "";

  logic [SW-1:0] msrc [2][DP];
  logic [3:0]    mpri [2][DP];
  int            mdep [2];
  logic [1:0]    exp_irq = '0, exp_clr = '0;
  logic [1:0][SW-1:0] exp_src = '0;

  dual_irq_steer #(.SRC_W(SW), .PRI_W(4), .DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .tie_to_p1(tie_to_p1), .req_src(req_src),
    .req_pri(req_pri), .req_ext(req_ext), .req_shared(req_shared),
    .task_pri(task_pri), .ack(ack), .eoi(eoi), .irq(irq),
    .clr_vld(clr_vld), .clr_src(clr_src));

  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mtop(int k);
    return (mdep[k] == 0) ? 0 : int'(mpri[k][mdep[k]-1]);
  endfunction

  function automatic bit deliver(int k);
    int o = 1 - k;
    bit ok, seen, win;
    ok = (req_pri[k] > mtop(k)) && (req_pri[k] > task_pri[k]);
    if (!req_ext[k] || !req_shared[k]) return ok;
    seen = 1'b0;
    for (int i = 0; i < mdep[o]; i++) if (msrc[o][i] == req_src[k]) seen = 1'b1;
    if (task_pri[k] != task_pri[o]) win = task_pri[k] < task_pri[o];
    else win = (int'(tie_to_p1) == k);
    return ok && !seen && win;
  endfunction

  function automatic string tag_of(int k);
    if (req_pri[k] == 0) return "R9";
    if (!req_ext[k]) return "R4";
    if (!req_shared[k]) return "R2";
    if (task_pri[0] == task_pri[1]) return "R5";
    return "R3";
  endfunction

  task automatic cycle();
    logic [1:0] nxt, tk;
    string tg [2];
    for (int k = 0; k < 2; k++) begin
      nxt[k] = deliver(k);
      tg[k] = tag_of(k);
    end
    for (int k = 0; k < 2; k++) begin
      tk[k] = ack[k] && exp_irq[k];
      if (tk[k]) begin
        exp_src[k] = req_src[k];
        if (mdep[k] < DP) begin
          msrc[k][mdep[k]] = req_src[k];
          mpri[k][mdep[k]] = req_pri[k];
          mdep[k]++;
        end
      end else if (eoi[k] && mdep[k] > 0) mdep[k]--;
    end
    exp_clr = tk;
    exp_irq = nxt;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(irq[k] == exp_irq[k], {tg[k], ",R10", note}, int'(irq[k]), int'(exp_irq[k]));
      chk(clr_vld[k] == exp_clr[k], {"R6", note}, int'(clr_vld[k]), int'(exp_clr[k]));
      if (exp_clr[k])
        chk(clr_src[k] == exp_src[k], "R6 source", int'(clr_src[k]), int'(exp_src[k]));
    end
  endtask

  task automatic rnd_inputs();
    for (int k = 0; k < 2; k++) begin
      req_src[k]    = SW'($urandom_range(0, 3));
      req_pri[k]    = 4'($urandom_range(0, 15));
      req_ext[k]    = ($urandom_range(0, 3) != 0);
      req_shared[k] = $urandom_range(0, 1);
      task_pri[k]   = 4'($urandom_range(0, 5));
      ack[k]        = ($urandom_range(0, 2) == 0);
      eoi[k]        = ($urandom_range(0, 9) == 0);
    end
    if ($urandom_range(0, 2) == 0) begin
      req_src[1] = req_src[0];
      req_shared = 2'b11;
      req_ext = 2'b11;
    end
    if ($urandom_range(0, 15) == 0) tie_to_p1 = ~tie_to_p1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    mdep[0] = 0;
    mdep[1] = 0;
    repeat (3) @(negedge clk);
    chk(irq == 2'b00, "R1 irq", int'(irq), 0);
    chk(clr_vld == 2'b00, "R1 clr", int'(clr_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 2'b00, "R1 after release", int'(irq), 0);

    note = " R7";
    req_ext = 2'b00; req_src[0] = SW'(9); req_pri[0] = 4'd5;
    ack[0] = 1'b1;
    cycle();
    cycle();
    ack[0] = 1'b0;
    cycle();
    chk(irq[0] == 1'b0, "R7 drop after push", int'(irq[0]), 0);
    note = " R8";
    eoi[0] = 1'b1;
    cycle();
    eoi[0] = 1'b0;
    cycle();
    chk(irq[0] == 1'b1, "R8 return after pop", int'(irq[0]), 1);
    eoi[0] = 1'b1;
    cycle();
    eoi[0] = 1'b0;

    note = " R5";
    req_ext = 2'b11; req_shared = 2'b11;
    req_src[0] = SW'(3); req_src[1] = SW'(3);
    req_pri[0] = 4'd9; req_pri[1] = 4'd9;
    task_pri[0] = 4'd2; task_pri[1] = 4'd2;
    tie_to_p1 = 1'b0;
    cycle();
    chk(irq == 2'b01, "R5 tie to p0", int'(irq), 1);
    tie_to_p1 = 1'b1;
    cycle();
    chk(irq == 2'b10, "R5 tie to p1", int'(irq), 2);

    note = "";
    for (int n = 0; n < 6000; n++) begin
      rnd_inputs();
      cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule